// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from peripherals into a pending-status register and gates them with an enable-mask register. Both registers sit in a 4 KB I/O page: status at offset 0x070 and mask at offset 0x074. The pending sources used by the system are bit 3 (DMA), bit 7 (serial port) and bit 9 (sound unit). Peripherals raise request lines. A rising edge on a line latches the matching status bit. Software acknowledges by writing the status register, and the written value is ANDed with both the current contents and the current mask.

The controller drives one registered interrupt line to the processor. A small two-state machine follows the enabled pending set. In `LINE_IDLE` the line is low. The transition *assert* moves to `LINE_RAISED` when the next status AND next mask is nonzero. The transition *release* moves back to `LINE_IDLE` when that value becomes zero. A write to the mask register also produces a one-cycle re-check pulse when work is already pending under the new mask. The processor uses this pulse to re-evaluate its interrupt state without waiting for a new request.

Top module: `intc_stat_mask`

## Requirements
- R1: After reset the status register, the mask register, `cpu_irq`, `recheck_pulse` and `bus_rdata` are all zero.
- R2: When a request line goes from 0 to 1, the matching status bit is set at that clock edge. A line held high does not set the bit again after it has been cleared.
- R3: A write to word offset 0x070 makes the status register equal to status AND mask AND write data. Bits that are not enabled in the mask are therefore cleared as well.
- R4: When a request rises in the same cycle as a status write, the rising bit ends up set, whatever value is written.
- R5: A write to word offset 0x074 stores the low NUM_SRC bits of the write data into the mask.
- R6: The cycle after a mask write, `recheck_pulse` is high for exactly one cycle if (new status AND new mask) is nonzero. In every other cycle it is low.
- R7: `cpu_irq` equals the OR-reduction of status AND mask. It updates at the same edge as the registers.
- R8: A read captures the register selected by the address at the clock edge and shows it on `bus_rdata` from the following cycle, with zeros above bit NUM_SRC-1. A read of any other offset returns zero. When no read is issued, `bus_rdata` holds its value.
- R9: A write takes effect only if byte enables [1:0] are both set, so a 16-bit write (0011) and a 32-bit write (1111) behave the same. Any other byte-enable pattern is ignored, and write-data bits above NUM_SRC-1 are ignored.
- R10: A write to an offset other than 0x070 or 0x074 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset within the I/O page |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| irq_req | input | 11 | Peripheral request lines, one per status bit |
| cpu_irq | output | 1 | Registered interrupt line to the processor |
| recheck_pulse | output | 1 | One-cycle pulse after a mask write that finds pending work |

## Verification
The bench builds the block with its defaults: 11 sources, a 32-bit data bus and a 12-bit offset. At this width the DMA, serial and sound bits, the top status bit 10 and the zero padding above it all fall inside the random write data and the random request toggles. Random request edges can land in the same cycle as an acknowledge. The random byte-enable mix makes 16-bit, 32-bit and rejected partial writes all occur. Directed sequences add the specific corners: a held level after clearing, a new request during a clear, a mask write with nothing pending, and acknowledges of bits that are not enabled.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam logic [11:0] STAT_OFS   = 12'h070;
    localparam logic [11:0] MASK_OFS   = 12'h074;
    localparam int unsigned SRC_DMA    = 3;
    localparam int unsigned SRC_SERIAL = 7;
    localparam int unsigned SRC_SOUND  = 9;

    typedef enum logic {
        LINE_IDLE,
        LINE_RAISED
    } line_state_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MASK
    } reg_sel_e;
endpackage

// File: rtl/intc_req_edge.sv
module intc_req_edge #(
    parameter int unsigned NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] rise_o
);
    logic [NUM_SRC-1:0] req_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) req_q[g] <= 1'b0;
            else        req_q[g] <= req_i[g];
        end
        assign rise_o[g] = req_i[g] & ~req_q[g];
    end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 11,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [1:0]         be_lo_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [NUM_SRC-1:0] rise_i,
    output logic [NUM_SRC-1:0] stat_q,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] stat_d,
    output logic [NUM_SRC-1:0] mask_d,
    output logic               mask_wr_o,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    reg_sel_e           sel;
    logic               wr_ok;
    logic               stat_wr;
    logic [NUM_SRC-1:0] wval;

    always_comb begin
        if (addr_i[ADDR_W-1:2] == STAT_OFS[ADDR_W-1:2])      sel = SEL_STAT;
        else if (addr_i[ADDR_W-1:2] == MASK_OFS[ADDR_W-1:2]) sel = SEL_MASK;
        else                                                 sel = SEL_NONE;
    end

    assign wr_ok     = wr_i && (be_lo_i == 2'b11);
    assign stat_wr   = wr_ok && (sel == SEL_STAT);
    assign mask_wr_o = wr_ok && (sel == SEL_MASK);
    assign wval      = wdata_i[NUM_SRC-1:0];

    always_comb begin
        stat_d = (stat_wr ? (stat_q & mask_q & wval) : stat_q) | rise_i;
        mask_d = mask_wr_o ? wval : mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q  <= '0;
            mask_q  <= '0;
            rdata_o <= '0;
        end else begin
            stat_q <= stat_d;
            mask_q <= mask_d;
            if (rd_i) begin
                unique case (sel)
                    SEL_STAT: rdata_o <= {{PAD_W{1'b0}}, stat_q};
                    SEL_MASK: rdata_o <= {{PAD_W{1'b0}}, mask_q};
                    default:  rdata_o <= '0;
                endcase
            end
        end
    end

    // R2: a rising request is latched at the edge
    a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_i) |=> ((stat_q & $past(rise_i)) == $past(rise_i)));
    // R3: a clear with no new request leaves only enabled bits
    a_r3_clear_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !(|rise_i)) |=> ((stat_q & ~$past(mask_q)) == '0));
    // R5: the mask keeps the written value
    a_r5_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_o |=> (mask_q == $past(wval)));
    // R8: padding above the register width reads as zero
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:NUM_SRC] == '0);
endmodule

// File: rtl/intc_line_fsm.sv
module intc_line_fsm
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] stat_d,
    input  logic [NUM_SRC-1:0] mask_d,
    input  logic [NUM_SRC-1:0] stat_q,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic               mask_wr_i,
    output logic               irq_o,
    output logic               recheck_o
);
    line_state_e state_q, state_nx;
    logic        pend_nx;

    assign pend_nx = |(stat_d & mask_d);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LINE_IDLE:   if (pend_nx)  state_nx = LINE_RAISED;
            LINE_RAISED: if (!pend_nx) state_nx = LINE_IDLE;
            default:     state_nx = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LINE_IDLE;
            recheck_o <= 1'b0;
        end else begin
            state_q   <= state_nx;
            recheck_o <= mask_wr_i && pend_nx;
        end
    end

    always_comb begin
        irq_o = (state_q == LINE_RAISED);
    end

    // R7: line tracks enabled pending bits of the register block
    a_r7_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(stat_q & mask_q)));
    // R6: a re-check pulse always finds the line raised
    a_r6_recheck_irq: assert property (@(posedge clk) disable iff (!rst_n)
        recheck_o |-> irq_o);
endmodule

// File: rtl/intc_stat_mask.sv
module intc_stat_mask
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 11,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned BE_W   = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [BE_W-1:0]    bus_be,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    output logic               cpu_irq,
    output logic               recheck_pulse
);
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] stat_q, mask_q, stat_d, mask_d;
    logic               mask_wr;
    logic               unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_be[BE_W-1:2]};

    intc_req_edge #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req),
        .rise_o (rise)
    );

    intc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .be_lo_i   (bus_be[1:0]),
        .wr_i      (bus_wr),
        .rd_i      (bus_rd),
        .rise_i    (rise),
        .stat_q    (stat_q),
        .mask_q    (mask_q),
        .stat_d    (stat_d),
        .mask_d    (mask_d),
        .mask_wr_o (mask_wr),
        .rdata_o   (bus_rdata)
    );

    intc_line_fsm #(.NUM_SRC(NUM_SRC)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_d    (stat_d),
        .mask_d    (mask_d),
        .stat_q    (stat_q),
        .mask_q    (mask_q),
        .mask_wr_i (mask_wr),
        .irq_o     (cpu_irq),
        .recheck_o (recheck_pulse)
    );

    // R6: no re-check pulse without a mask write in the cycle before
    a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        recheck_pulse |-> $past(bus_wr && bus_be[1:0] == 2'b11
                                && bus_addr[ADDR_W-1:2] == MASK_OFS[ADDR_W-1:2]));
endmodule

// File: tb/intc_stat_mask_tb_top.sv
module intc_stat_mask_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_req = '0;
    logic        cpu_irq;
    logic        recheck_pulse;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [N-1:0] m_stat = '0, m_mask = '0, m_req = '0;
    logic [31:0]  m_rdata = '0;
    logic         m_irq = 1'b0, m_rech = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_stat_mask dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .cpu_irq(cpu_irq), .recheck_pulse(recheck_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_model(input logic [11:0] a);
        if (a[11:2] == 10'h01c) return {21'b0, m_stat};
        if (a[11:2] == 10'h01d) return {21'b0, m_mask};
        return 32'h0;
    endfunction

    task automatic step();
        logic [N-1:0] rise, ns, nm;
        logic ok, sw, mw;
        @(posedge clk);
        rise = irq_req & ~m_req;
        ok = bus_wr && bus_be[1:0] == 2'b11;
        sw = ok && bus_addr[11:2] == 10'h01c;
        mw = ok && bus_addr[11:2] == 10'h01d;
        ns = (sw ? (m_stat & m_mask & bus_wdata[N-1:0]) : m_stat) | rise;
        nm = mw ? bus_wdata[N-1:0] : m_mask;
        if (bus_rd) m_rdata = rd_model(bus_addr);
        m_rech = mw && |(ns & nm);
        m_irq = |(ns & nm);
        m_stat = ns; m_mask = nm; m_req = irq_req;
        @(negedge clk);
        chk("R7 cpu_irq", {31'b0, cpu_irq}, {31'b0, m_irq});
        chk("R6 recheck_pulse", {31'b0, recheck_pulse}, {31'b0, m_rech});
        chk("R8 bus_rdata", bus_rdata, m_rdata);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        bus_addr = a; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        chk("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
        chk("R1 recheck", {31'b0, recheck_pulse}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        rd(12'h070); chk("R1 status", bus_rdata, 32'h0);
        rd(12'h074); chk("R1 mask", bus_rdata, 32'h0);

        // R5, R6: mask write with nothing pending
        wr(12'h074, 32'h0000_0288, 4'hf);
        chk("R6 no pulse", {31'b0, recheck_pulse}, 32'h0);
        rd(12'h074); chk("R5 mask", bus_rdata, 32'h288);

        // R2, R7: serial request edge
        irq_req[7] = 1'b1; step();
        chk("R7 irq raised", {31'b0, cpu_irq}, 32'h1);
        rd(12'h070); chk("R2 status", bus_rdata, 32'h080);
        wr(12'h070, 32'h0, 4'hf); step();
        rd(12'h070); chk("R2 held level", bus_rdata, 32'h0);

        // R4: new request wins over a clear
        irq_req[7] = 1'b0; step();
        irq_req[7] = 1'b1; wr(12'h070, 32'h0, 4'hf);
        rd(12'h070); chk("R4 rise wins", bus_rdata, 32'h080);

        // R9: partial enables ignored, 16-bit write accepted
        wr(12'h074, 32'h0, 4'h1);
        rd(12'h074); chk("R9 be 0001", bus_rdata, 32'h288);
        wr(12'h074, 32'hffff_0008, 4'h3);
        rd(12'h074); chk("R9 16-bit", bus_rdata, 32'h008);

        // R10: other offset
        wr(12'h100, 32'h0, 4'hf);
        rd(12'h070); chk("R10 status kept", bus_rdata, 32'h080);
        rd(12'h100); chk("R8 other offset", bus_rdata, 32'h0);

        // R6: mask write uncovering pending bit
        wr(12'h074, 32'h0000_0080, 4'hf);
        chk("R6 pulse", {31'b0, recheck_pulse}, 32'h1);
        step();
        chk("R6 single", {31'b0, recheck_pulse}, 32'h0);

        // R3: ack clears bits outside the mask
        irq_req[9] = 1'b1; step();
        wr(12'h070, 32'h0000_07ff, 4'hf);
        rd(12'h070); chk("R3 masked clear", bus_rdata, 32'h080);

        // random phase
        for (int i = 0; i < 600; i++) begin
            int k;
            k = $urandom_range(0, 2);
            bus_addr = (k == 0) ? 12'h070 : (k == 1) ? 12'h074 : 12'h0f0;
            bus_wdata = $urandom();
            k = $urandom_range(0, 3);
            bus_be = (k == 0) ? 4'hf : (k == 1) ? 4'h3 : (k == 2) ? 4'h1 : 4'hc;
            bus_wr = ($urandom_range(0, 9) < 3);
            bus_rd = ($urandom_range(0, 9) < 4);
            if ($urandom_range(0, 3) == 0) irq_req = irq_req ^ N'(1 << $urandom_range(0, N-1));
            step();
        end
        bus_wr = 1'b0; bus_rd = 1'b0;
        finished = 1'b1;
        summary();
    end
endmodule